// File: doc/BRIEF.md
# Delayed and Combined Channel Event Generator

This block sits behind the compare and capture channels of a real-time counter running on a low-frequency clock. Each channel produces a raw one-cycle event pulse. The block re-issues every raw pulse after a programmable number of clock cycles. One shared delay setting applies to all channels. A combined event is the OR of the delayed events that a per-channel mask selects.

The delay setting is a 4-bit code in a control word. The code maps to a non-linear table: none, 1, 2, 4 and 8 cycles, then multiples of 16 up to 144 cycles. With code zero the raw pulse passes straight through in the same cycle.

Each channel has its own countdown. The delay is captured when a raw event arrives. If another raw event arrives while a countdown is pending, the count restarts, so only the latest event is delivered. Every delayed event is a one-cycle pulse. Reset is synchronous and active-high.

Top module: `rtc_evdly_gen`

## Requirements
- R1: With delay code 0, each `dly_ev` bit equals the matching `raw_ev` bit in the same cycle, with no register in between.
- R2: Codes 1, 2, 3 and 4 give delays of 1, 2, 4 and 8 cycles. A raw pulse sampled in cycle t gives exactly one delayed pulse, one cycle wide, in cycle t+D.
- R3: Codes 5 through 13 give delays of 16·(code−4) cycles, which is 16 to 144 cycles.
- R4: Codes 14 and 15 give the maximum delay of 144 cycles.
- R5: The delay code is `ctrl_word[11:8]`. The mask is `ctrl_word[18:16]`, where bit 16 selects channel 0, bit 17 selects channel 1 and bit 18 selects channel 2. Bits [15:12] and [7:0] have no effect.
- R6: `comb_ev` is the OR of the `dly_ev` bits whose mask bit is 1. With an all-zero mask, `comb_ev` never rises.
- R7: A raw event that arrives while a channel's countdown is pending, in a cycle where that channel emits no delayed pulse, restarts the count. The earlier event is dropped, and one pulse appears D cycles after the latest event.
- R8: A raw event in the same cycle as a channel's expiring delayed pulse does not suppress that pulse. It starts a fresh count, which gives a second pulse D cycles later.
- R9: The delay is captured when the raw event arrives. Changing the code while a countdown is pending does not move that pulse.
- R10: The channels count independently. An event on one channel neither moves nor produces a pulse on another.
- R11: Synchronous reset clears all pending countdowns. No delayed pulse appears after reset until a new raw event arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Low-frequency counter clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_ev | input | 3 | Raw event pulses, one per channel |
| ctrl_word | input | 19 | Control: delay code at [11:8], combine mask at [18:16] |
| dly_ev | output | 3 | Delayed event pulses, one per channel |
| comb_ev | output | 1 | OR of the mask-selected delayed events |

## Verification
Every code from 1 to 15 is driven with a lone pulse on channel 0, and the bench finds the cycle of the single output pulse. This separates each table entry from its neighbours and shows that codes 14 and 15 saturate. A second raw pulse is placed in two ways: mid-countdown and exactly on the expiry cycle. These two patterns tell restart-and-drop apart from emit-and-reload. Staggered pulses across channels, a code change during a countdown, a reset during a countdown, and mask patterns with the reserved control bits set to one show that the channels are independent, that the delay is captured on arrival, that reset clears pending counts, and that the field positions are correct.

// File: rtl/rtc_evdly_pkg.sv
package rtc_evdly_pkg;

    // Geometry of the block
    localparam int NUM_CH   = 3;
    localparam int CODE_W   = 4;
    localparam int CNT_W    = 8;

    // Field positions inside the control word (decoded by neighbours)
    localparam int DLY_LSB  = 8;
    localparam int MASK_LSB = 16;
    localparam int CTRL_W   = MASK_LSB + NUM_CH;

    // Table shape
    localparam int LIN_LAST  = 4;    // last code of the doubling segment
    localparam int STEP      = 16;   // step of the linear segment
    localparam int MAX_CODE  = 13;   // last code of the linear segment
    localparam int MAX_DELAY = STEP * (MAX_CODE - LIN_LAST);

    typedef logic [CNT_W-1:0] cycles_t;

    typedef enum logic [1:0] {
        CH_IDLE = 2'b00,
        CH_WAIT = 2'b01
    } ch_state_e;

    typedef struct packed {
        logic [NUM_CH-1:0] mask;
        logic [CODE_W-1:0] code;
    } evcfg_t;

    // Delay code to cycle count
    function automatic int code_to_cycles(input logic [CODE_W-1:0] code);
        int c;
        c = int'(code);
        if (c == 0)
            return 0;
        else if (c <= LIN_LAST)
            return 1 << (c - 1);
        else if (c <= MAX_CODE)
            return STEP * (c - LIN_LAST);
        else
            return MAX_DELAY;
    endfunction

endpackage

// File: rtl/rtc_evdly_lut.sv
module rtc_evdly_lut
    import rtc_evdly_pkg::*;
#(
    parameter int CW = CODE_W,
    parameter int NW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] code_i,
    output logic [NW-1:0] cycles_o
);

    always_comb begin
        cycles_o = NW'(code_to_cycles(CODE_W'(code_i)));
    end

    // R4: codes at and above the last linear code saturate at the maximum
    assert_sat_R4: assert property (@(posedge clk) disable iff (rst)
        (int'(code_i) >= MAX_CODE) |-> (int'(cycles_o) == MAX_DELAY));

    // R1: only code 0 means no delay
    assert_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (cycles_o == '0) |-> (code_i == '0));

endmodule

// File: rtl/rtc_evdly_chan.sv
module rtc_evdly_chan
    import rtc_evdly_pkg::*;
#(
    parameter int NW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          raw_i,
    input  logic [NW-1:0] delay_i,
    output logic          dly_o
);

    ch_state_e     state_q;
    logic [NW-1:0] cnt_q;
    logic          expire;
    logic          load;

    assign load   = raw_i && (delay_i != '0);
    assign expire = (state_q == CH_WAIT) && (cnt_q == NW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CH_IDLE;
            cnt_q   <= '0;
        end else if (load) begin
            state_q <= CH_WAIT;
            cnt_q   <= delay_i;
        end else if (state_q == CH_WAIT) begin
            if (expire) begin
                state_q <= CH_IDLE;
                cnt_q   <= '0;
            end else begin
                cnt_q   <= cnt_q - NW'(1);
            end
        end
    end

    always_comb begin
        dly_o = expire || (raw_i && (delay_i == '0));
    end

    // R2: a pending count steps down by one each cycle when undisturbed
    assert_count_down_R2: assert property (@(posedge clk) disable iff (rst)
        ((state_q == CH_WAIT) && !expire && !raw_i)
        |=> ((state_q == CH_WAIT) && (cnt_q == $past(cnt_q) - NW'(1))));

    // R7: a new event with nonzero delay reloads the count
    assert_reload_R7: assert property (@(posedge clk) disable iff (rst)
        (raw_i && (delay_i != '0)) |=> ((state_q == CH_WAIT) && (cnt_q == $past(delay_i))));

    // R11: an idle channel with no raw event is silent
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        ((state_q == CH_IDLE) && !raw_i) |-> !dly_o);

    // R2: a delayed pulse from a countdown lasts one cycle unless refired
    assert_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
        (expire && !raw_i) |=> (state_q == CH_IDLE));

endmodule

// File: rtl/rtc_evdly_comb.sv
module rtc_evdly_comb #(
    parameter int N = 3
) (
    input  logic [N-1:0] dly_i,
    input  logic [N-1:0] mask_i,
    output logic         comb_o
);

    logic [N-1:0] sel;

    for (genvar i = 0; i < N; i++) begin : g_sel
        assign sel[i] = dly_i[i] & mask_i[i];
    end

    assign comb_o = |sel;

endmodule

// File: rtl/rtc_evdly_gen.sv
module rtc_evdly_gen
    import rtc_evdly_pkg::*;
#(
    parameter int NCH = NUM_CH,
    parameter int NW  = CNT_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NCH-1:0]              raw_ev,
    input  logic [MASK_LSB+NCH-1:0]     ctrl_word,
    output logic [NCH-1:0]              dly_ev,
    output logic                        comb_ev
);

    localparam int CODE_HI = DLY_LSB + CODE_W - 1;
    localparam int MASK_HI = MASK_LSB + NCH - 1;

    logic [CODE_W-1:0] code;
    logic [NCH-1:0]    mask;
    logic [NW-1:0]     cycles;
    logic              unused_ctrl_bits;

    assign code = ctrl_word[CODE_HI:DLY_LSB];
    assign mask = ctrl_word[MASK_HI:MASK_LSB];
    assign unused_ctrl_bits = ^{ctrl_word[MASK_LSB-1:CODE_HI+1], ctrl_word[DLY_LSB-1:0]};

    rtc_evdly_lut #(.CW(CODE_W), .NW(NW)) u_lut (
        .clk      (clk),
        .rst      (rst),
        .code_i   (code),
        .cycles_o (cycles)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        rtc_evdly_chan #(.NW(NW)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .raw_i   (raw_ev[i]),
            .delay_i (cycles),
            .dly_o   (dly_ev[i])
        );
    end

    rtc_evdly_comb #(.N(NCH)) u_comb (
        .dly_i  (dly_ev),
        .mask_i (mask),
        .comb_o (comb_ev)
    );

    // R6: an empty mask never yields a combined event
    assert_none_R6: assert property (@(posedge clk) disable iff (rst)
        (mask == '0) |-> !comb_ev);

    // R6: a combined event always has a selected delayed event behind it
    assert_backed_R6: assert property (@(posedge clk) disable iff (rst)
        comb_ev |-> ($countones(dly_ev & mask) != 0));

endmodule

// File: tb/rtc_evdly_gen_tb.sv
module rtc_evdly_gen_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  raw_ev = '0;
    logic [18:0] ctrl_word = '0;
    logic [2:0]  dly_ev;
    logic        comb_ev;

    int checks = 0;
    int errors = 0;

    bit [2:0] sched [0:199];
    bit [2:0] rec_d [0:199];
    bit       rec_c [0:199];

    always #5 clk = ~clk;

    rtc_evdly_gen u_dut (
        .clk       (clk),
        .rst       (rst),
        .raw_ev    (raw_ev),
        .ctrl_word (ctrl_word),
        .dly_ev    (dly_ev),
        .comb_ev   (comb_ev)
    );

    function automatic int exp_delay(input int c);
        case (c)
            0: return 0;
            1: return 1;
            2: return 2;
            3: return 4;
            4: return 8;
            14, 15: return 144;
            default: return (c - 4) * 16;
        endcase
    endfunction

    function automatic logic [18:0] mk_ctrl(input int code, input logic [2:0] mask, input bit junk);
        logic [18:0] w;
        w = junk ? 19'h0F0FF : 19'h0;
        w[11:8]  = 4'(code);
        w[18:16] = mask;
        return w;
    endfunction

    task automatic clear_sched();
        for (int k = 0; k < 200; k++) begin
            sched[k] = '0;
            rec_d[k] = '0;
            rec_c[k] = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        raw_ev = '0;
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // Interval k: raw driven after negedge, outputs sampled 1 ns later
    task automatic run(input int ka, input int kb);
        for (int k = ka; k <= kb; k++) begin
            @(negedge clk);
            raw_ev = sched[k];
            #1;
            rec_d[k] = dly_ev;
            rec_c[k] = comb_ev;
        end
    endtask

    // Channel ch high exactly at e1/e2 (-1 = unused) within [ka,kb]
    task automatic chk_ch(input string req, input int ch, input int ka, input int kb,
                          input int e1, input int e2);
        int bad_k;
        bit got;
        bad_k = -1;
        got = 1'b0;
        for (int k = ka; k <= kb; k++) begin
            if (bad_k < 0 && (rec_d[k][ch] != ((k == e1) || (k == e2)))) begin
                bad_k = k;
                got = rec_d[k][ch];
            end
        end
        checks++;
        if (bad_k >= 0) begin
            errors++;
            $display("FAIL %s ch%0d interval %0d: actual %0b expected %0b (pulses at %0d,%0d)",
                     req, ch, bad_k, got, !got, e1, e2);
        end
    endtask

    task automatic chk_comb(input string req, input int ka, input int kb,
                            input int e1, input int e2);
        int bad_k;
        bit got;
        bad_k = -1;
        got = 1'b0;
        for (int k = ka; k <= kb; k++) begin
            if (bad_k < 0 && (rec_c[k] != ((k == e1) || (k == e2)))) begin
                bad_k = k;
                got = rec_c[k];
            end
        end
        checks++;
        if (bad_k >= 0) begin
            errors++;
            $display("FAIL %s comb interval %0d: actual %0b expected %0b (pulses at %0d,%0d)",
                     req, bad_k, got, !got, e1, e2);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        checks++;
        if (dly_ev !== 3'b000 || comb_ev !== 1'b0) begin
            errors++;
            $display("FAIL R11 reset: actual dly=%b comb=%b expected 000/0", dly_ev, comb_ev);
        end
    endtask

    task automatic t_pass_R1();
        ctrl_word = mk_ctrl(0, 3'b111, 0);
        clear_sched();
        sched[0] = 3'b101;
        sched[2] = 3'b010;
        run(0, 5);
        chk_ch("R1", 0, 0, 5, 0, -1);
        chk_ch("R1", 1, 0, 5, 2, -1);
        chk_comb("R1", 0, 5, 0, 2);
        idle(4);
    endtask

    task automatic t_table();
        for (int c = 1; c <= 15; c++) begin
            int d;
            string req;
            d = exp_delay(c);
            req = (c <= 4) ? "R2" : ((c <= 13) ? "R3" : "R4");
            ctrl_word = mk_ctrl(c, 3'b000, 0);
            clear_sched();
            sched[0] = 3'b001;
            run(0, d + 5);
            chk_ch(req, 0, 0, d + 5, d, -1);
            idle(2);
        end
    endtask

    task automatic t_restart_R7();
        ctrl_word = mk_ctrl(4, 3'b001, 0);
        clear_sched();
        sched[0] = 3'b001;
        sched[3] = 3'b001;
        run(0, 16);
        chk_ch("R7", 0, 0, 16, 11, -1);
        idle(2);
    endtask

    task automatic t_expiry_R8();
        ctrl_word = mk_ctrl(3, 3'b001, 0);
        clear_sched();
        sched[0] = 3'b001;
        sched[4] = 3'b001;
        run(0, 12);
        chk_ch("R8", 0, 0, 12, 4, 8);
        idle(2);
    endtask

    task automatic t_latch_R9();
        ctrl_word = mk_ctrl(5, 3'b000, 0);
        clear_sched();
        sched[0] = 3'b100;
        run(0, 1);
        ctrl_word = mk_ctrl(1, 3'b000, 0);
        run(2, 22);
        chk_ch("R9", 2, 0, 22, 16, -1);
        idle(2);
    endtask

    task automatic t_comb_R6();
        ctrl_word = mk_ctrl(1, 3'b010, 0);
        clear_sched();
        sched[0] = 3'b010;
        run(0, 4);
        chk_comb("R6 mask ch1", 0, 4, 1, -1);
        idle(2);
        ctrl_word = mk_ctrl(1, 3'b001, 0);
        clear_sched();
        sched[0] = 3'b010;
        run(0, 4);
        chk_ch("R6 unmasked", 1, 0, 4, 1, -1);
        chk_comb("R6 unmasked", 0, 4, -1, -1);
        idle(2);
        ctrl_word = mk_ctrl(1, 3'b000, 0);
        clear_sched();
        sched[0] = 3'b111;
        run(0, 4);
        chk_comb("R6 empty mask", 0, 4, -1, -1);
        idle(2);
        ctrl_word = mk_ctrl(1, 3'b101, 0);
        clear_sched();
        sched[0] = 3'b001;
        sched[2] = 3'b100;
        run(0, 6);
        chk_comb("R6 mask ch0+ch2", 0, 6, 1, 3);
        idle(2);
    endtask

    task automatic t_fields_R5();
        ctrl_word = mk_ctrl(2, 3'b100, 1);
        clear_sched();
        sched[0] = 3'b100;
        run(0, 6);
        chk_ch("R5", 2, 0, 6, 2, -1);
        chk_comb("R5", 0, 6, 2, -1);
        idle(2);
    endtask

    task automatic t_indep_R10();
        ctrl_word = mk_ctrl(2, 3'b000, 0);
        clear_sched();
        sched[0] = 3'b001;
        sched[1] = 3'b100;
        run(0, 7);
        chk_ch("R10", 0, 0, 7, 2, -1);
        chk_ch("R10", 2, 0, 7, 3, -1);
        chk_ch("R10", 1, 0, 7, -1, -1);
        idle(2);
    endtask

    task automatic t_reset_R11();
        ctrl_word = mk_ctrl(4, 3'b111, 0);
        clear_sched();
        sched[0] = 3'b111;
        run(0, 2);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        run(4, 20);
        chk_ch("R11", 0, 4, 20, -1, -1);
        chk_comb("R11", 4, 20, -1, -1);
        idle(2);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_pass_R1();
        t_table();
        t_restart_R7();
        t_expiry_R8();
        t_latch_R9();
        t_comb_R6();
        t_fields_R5();
        t_indep_R10();
        t_reset_R11();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule